// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This unit carries out the register-class instructions of a single-accumulator machine. The 12-bit operation field is a set of control bits, one bit for each operation. The bits act on a 16-bit accumulator and a one-bit link flag E. Alongside them sit four condition tests that can ask the sequencer to skip the next instruction word, and a stop bit that halts the unit. The surrounding control logic presents the operation field, the current accumulator, the current E and the current program counter, together with a one-cycle execute strobe. One clock edge later the unit returns the new accumulator, the new E, a one-cycle skip request and the program counter with any skip already applied.

More than one control bit may be set in the same word. The operations then apply in a fixed chain: clears first, then complements, then rotations, then the increment. The condition tests always read the accumulator and E as they were presented, before any operation in the word is applied, and their results are ORed together. After the stop bit has executed, the unit ignores every further strobe until reset.

Top module: `acc_regop_unit`

## Requirements
- R1: A synchronous active-high reset drives ac_out to 0000h, e_out to 0, skip_req to 0, halted to 0 and pc_next to 000h.
- R2: Accumulator operations: op bit 11 (field 800h) clears the accumulator, op bit 9 (200h) inverts every accumulator bit, and op bit 5 (020h) adds one to the accumulator.
- R3: Link operations: op bit 10 (400h) clears E, and op bit 8 (100h) inverts E.
- R4: Op bit 7 (080h) rotates right through E. The new ac[14:0] is the old ac[15:1], the new ac[15] is the old E, and the new E is the old ac[0].
- R5: Op bit 6 (040h) rotates left through E. The new ac[15:1] is the old ac[14:0], the new ac[0] is the old E, and the new E is the old ac[15].
- R6: The increment wraps from FFFFh to 0000h and never changes E.
- R7: Skip tests use the accumulator and E as presented with the strobe. Op bit 4 (010h) is true when the accumulator is nonzero with bit 15 clear. Op bit 3 (008h) is true when bit 15 is set. Op bit 2 (004h) is true when the accumulator is 0000h. Op bit 1 (002h) is true when E is 0. skip_req is the OR of the true selected tests and is high for exactly one cycle.
- R8: When several operation bits are set, the chain is: clears (bits 11 and 10), then complements (bits 9 and 8), then rotate right (bit 7), then rotate left (bit 6), then increment (bit 5).
- R9: Op bit 0 (001h) sets halted at the same edge that returns the results. The other bits of that same word still take effect. halted stays set until reset. While halted is set, strobes have no effect: ac_out, e_out and pc_next hold, and skip_req stays 0.
- R10: Results appear at the first clock edge after the strobe. In a cycle without a strobe, ac_out, e_out and pc_next hold and skip_req is 0.
- R11: With each executed strobe, pc_next becomes pc_in plus one (modulo 4096) when the skip request is true, and pc_in otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | One-cycle execute strobe |
| op_field | input | 12 | Operation control bits, one per operation |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current link flag |
| pc_in | input | 12 | Current program counter (already pointing at the next word) |
| ac_out | output | 16 | Updated accumulator |
| e_out | output | 1 | Updated link flag |
| skip_req | output | 1 | One-cycle request to skip the next word |
| pc_next | output | 12 | Program counter with any skip applied |
| halted | output | 1 | Sticky stop flag |

## Verification
Two pairs of functions can act in the same strobe. The first is the stop bit together with an accumulator operation: the bench issues stop with complement and checks that the complemented value lands as halted rises, and that a later clear-and-complement strobe is then ignored. The second is a clear together with the zero test: the bench sets both bits on a nonzero accumulator and expects a zero result with no skip, which shows that the tests read the incoming value. Further vectors set several chain bits at once, such as clear with complement and increment, and complement with increment. Each is judged against values worked out by hand from the ordering rule.

// File: rtl/acc_regop_pkg.sv
package acc_regop_pkg;

    localparam int unsigned OPF_W = 12;

    // Positions of the control bits in the operation field
    localparam int unsigned POS_CLR_AC = 11;
    localparam int unsigned POS_CLR_E  = 10;
    localparam int unsigned POS_INV_AC = 9;
    localparam int unsigned POS_INV_E  = 8;
    localparam int unsigned POS_ROT_R  = 7;
    localparam int unsigned POS_ROT_L  = 6;
    localparam int unsigned POS_INCR   = 5;
    localparam int unsigned POS_T_POS  = 4;
    localparam int unsigned POS_T_NEG  = 3;
    localparam int unsigned POS_T_ZERO = 2;
    localparam int unsigned POS_T_EZ   = 1;
    localparam int unsigned POS_STOP   = 0;

    typedef struct packed {
        logic clr_ac;
        logic clr_e;
        logic inv_ac;
        logic inv_e;
        logic rot_r;
        logic rot_l;
        logic incr;
        logic t_pos;
        logic t_neg;
        logic t_zero;
        logic t_ezero;
        logic stop;
    } ctl_t;

    function automatic ctl_t field_to_ctl(input logic [OPF_W-1:0] f);
        ctl_t c;
        c.clr_ac  = f[POS_CLR_AC];
        c.clr_e   = f[POS_CLR_E];
        c.inv_ac  = f[POS_INV_AC];
        c.inv_e   = f[POS_INV_E];
        c.rot_r   = f[POS_ROT_R];
        c.rot_l   = f[POS_ROT_L];
        c.incr    = f[POS_INCR];
        c.t_pos   = f[POS_T_POS];
        c.t_neg   = f[POS_T_NEG];
        c.t_zero  = f[POS_T_ZERO];
        c.t_ezero = f[POS_T_EZ];
        c.stop    = f[POS_STOP];
        return c;
    endfunction

endpackage

// File: rtl/acc_regop_decode.sv
module acc_regop_decode
    import acc_regop_pkg::*;
(
    input  logic             go,
    input  logic [OPF_W-1:0] op_field,
    output ctl_t             ctl
);
    // Controls are forced idle unless the strobe is accepted
    always_comb begin
        if (go) ctl = field_to_ctl(op_field);
        else    ctl = '0;
    end
endmodule

// File: rtl/acc_regop_alu.sv
module acc_regop_alu
    import acc_regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    output logic [DATA_W-1:0] ac_res,
    output logic              e_res
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] ac_c, ac_v, ac_r, ac_l;
    logic              e_c, e_v, e_r, e_l;

    // Stage 1: clears
    always_comb begin
        ac_c = ctl.clr_ac ? '0 : ac_in;
        e_c  = ctl.clr_e  ? 1'b0 : e_in;
    end

    // Stage 2: complements
    always_comb begin
        ac_v = ctl.inv_ac ? ~ac_c : ac_c;
        e_v  = ctl.inv_e  ? ~e_c  : e_c;
    end

    // Stage 3: rotate right through the link
    always_comb begin
        if (ctl.rot_r) begin
            ac_r = {e_v, ac_v[MSB:1]};
            e_r  = ac_v[0];
        end else begin
            ac_r = ac_v;
            e_r  = e_v;
        end
    end

    // Stage 4: rotate left through the link
    always_comb begin
        if (ctl.rot_l) begin
            ac_l = {ac_r[MSB-1:0], e_r};
            e_l  = ac_r[MSB];
        end else begin
            ac_l = ac_r;
            e_l  = e_r;
        end
    end

    // Stage 5: increment, wraps, link untouched
    always_comb begin
        ac_res = ctl.incr ? ac_l + DATA_W'(1) : ac_l;
        e_res  = e_l;
    end
endmodule

// File: rtl/acc_regop_skip.sv
module acc_regop_skip
    import acc_regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    output logic              skip
);
    logic is_zero, is_neg, is_pos;

    always_comb begin
        is_zero = (ac_in == '0);
        is_neg  = ac_in[DATA_W-1];
        is_pos  = !is_neg && !is_zero;
        skip    = (ctl.t_pos  && is_pos)  ||
                  (ctl.t_neg  && is_neg)  ||
                  (ctl.t_zero && is_zero) ||
                  (ctl.t_ezero && !e_in);
    end
endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
    import acc_regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [OPF_W-1:0]  op_field,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    input  logic [PC_W-1:0]   pc_in,
    output logic [DATA_W-1:0] ac_out,
    output logic              e_out,
    output logic              skip_req,
    output logic [PC_W-1:0]   pc_next,
    output logic              halted
);
    localparam int unsigned MSB = DATA_W - 1;

    logic              go;
    ctl_t              ctl;
    logic [DATA_W-1:0] ac_res;
    logic              e_res;
    logic              skip_now;

    assign go = exec_en && !halted;

    acc_regop_decode u_dec (
        .go       (go),
        .op_field (op_field),
        .ctl      (ctl)
    );

    acc_regop_alu #(.DATA_W(DATA_W)) u_alu (
        .ctl    (ctl),
        .ac_in  (ac_in),
        .e_in   (e_in),
        .ac_res (ac_res),
        .e_res  (e_res)
    );

    acc_regop_skip #(.DATA_W(DATA_W)) u_skip (
        .ctl   (ctl),
        .ac_in (ac_in),
        .e_in  (e_in),
        .skip  (skip_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_out   <= '0;
            e_out    <= 1'b0;
            skip_req <= 1'b0;
            pc_next  <= '0;
            halted   <= 1'b0;
        end else begin
            skip_req <= go && skip_now;
            if (go) begin
                ac_out  <= ac_res;
                e_out   <= e_res;
                pc_next <= pc_in + PC_W'(skip_now);
                if (ctl.stop) halted <= 1'b1;
            end
        end
    end

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ac_out == '0) && !e_out && !skip_req && !halted && (pc_next == '0));

    // R2: lone clear yields zero accumulator
    p_clear_ac_r2: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h800)) |=> (ac_out == '0));

    // R3: lone link complement flips the link
    p_inv_e_r3: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h100)) |=> (e_out != $past(e_in)));

    // R4: rotate right through link
    p_rot_r_r4: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h080)) |=>
        (ac_out == {$past(e_in), $past(ac_in[MSB:1])}) && (e_out == $past(ac_in[0])));

    // R5: rotate left through link
    p_rot_l_r5: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h040)) |=>
        (ac_out == {$past(ac_in[MSB-1:0]), $past(e_in)}) && (e_out == $past(ac_in[MSB])));

    // R6: increment leaves link alone
    p_incr_link_r6: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h020)) |=> (e_out == $past(e_in)));

    // R7: zero test on incoming accumulator
    p_zero_test_r7: assert property (@(posedge clk) disable iff (rst)
        (go && op_field == OPF_W'(12'h004)) |=> (skip_req == ($past(ac_in) == '0)));

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: halted unit holds its outputs
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(ac_out) && $stable(e_out) && $stable(pc_next) && !skip_req);

    // R10: no strobe, no change
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> !skip_req && $stable(ac_out) && $stable(e_out));

    // R11: program counter follows skip request
    p_pc_follow_r11: assert property (@(posedge clk) disable iff (rst)
        go |=> (pc_next == $past(pc_in) + PC_W'(skip_req)));
endmodule

// File: tb/acc_regop_unit_tb.sv
module acc_regop_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_en;
    logic [11:0] op_field;
    logic [15:0] ac_in;
    logic        e_in;
    logic [11:0] pc_in;
    logic [15:0] ac_out;
    logic        e_out;
    logic        skip_req;
    logic [11:0] pc_next;
    logic        halted;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_regop_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .exec_en  (exec_en),
        .op_field (op_field),
        .ac_in    (ac_in),
        .e_in     (e_in),
        .pc_in    (pc_in),
        .ac_out   (ac_out),
        .e_out    (e_out),
        .skip_req (skip_req),
        .pc_next  (pc_next),
        .halted   (halted)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [11:0] op;
        logic [15:0] ac;
        logic        e;
        logic [15:0] xac;
        logic        xe;
        logic        xs;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  12'h800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0}, // R2 clear
        '{4'd3,  12'h400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0}, // R3 clear link
        '{4'd2,  12'h200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0}, // R2 invert
        '{4'd3,  12'h100, 16'h5555, 1'b0, 16'h5555, 1'b1, 1'b0}, // R3 invert link
        '{4'd4,  12'h080, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0}, // R4
        '{4'd4,  12'h080, 16'h8000, 1'b1, 16'hC000, 1'b0, 1'b0}, // R4
        '{4'd5,  12'h040, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0}, // R5
        '{4'd5,  12'h040, 16'h0001, 1'b1, 16'h0003, 1'b0, 1'b0}, // R5
        '{4'd6,  12'h020, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0}, // R6 wrap
        '{4'd2,  12'h020, 16'h0041, 1'b1, 16'h0042, 1'b1, 1'b0}, // R2 increment
        '{4'd7,  12'h010, 16'h0005, 1'b0, 16'h0005, 1'b0, 1'b1}, // R7 positive
        '{4'd7,  12'h010, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0}, // R7 zero not positive
        '{4'd7,  12'h010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0}, // R7
        '{4'd7,  12'h008, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b1}, // R7 negative
        '{4'd7,  12'h008, 16'h7FFF, 1'b1, 16'h7FFF, 1'b1, 1'b0}, // R7
        '{4'd7,  12'h004, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1}, // R7 zero
        '{4'd7,  12'h004, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b0}, // R7
        '{4'd7,  12'h002, 16'h0009, 1'b0, 16'h0009, 1'b0, 1'b1}, // R7 link zero
        '{4'd7,  12'h002, 16'h0009, 1'b1, 16'h0009, 1'b1, 1'b0}, // R7
        '{4'd8,  12'hA00, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 1'b0}, // R8 clear then invert
        '{4'd8,  12'h540, 16'h8001, 1'b1, 16'h0003, 1'b1, 1'b0}, // R8 link chain then rotate
        '{4'd8,  12'h220, 16'h0005, 1'b0, 16'hFFFB, 1'b0, 1'b0}, // R8 invert then increment
        '{4'd8,  12'hA20, 16'h4321, 1'b0, 16'h0000, 1'b0, 1'b0}, // R8 clear, invert, increment
        '{4'd8,  12'h0A0, 16'h0003, 1'b0, 16'h0002, 1'b1, 1'b0}, // R8 rotate then increment
        '{4'd8,  12'h0C0, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0}, // R8 right then left
        '{4'd7,  12'h014, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1}, // R7 OR of tests
        '{4'd7,  12'h804, 16'h0003, 1'b0, 16'h0000, 1'b0, 1'b0}  // R7 test reads incoming value
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [11:0] op, input logic [15:0] a,
                          input logic e, input logic [11:0] pc);
        @(negedge clk);
        exec_en  = 1'b1;
        op_field = op;
        ac_in    = a;
        e_in     = e;
        pc_in    = pc;
        @(negedge clk);
        exec_en  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; exec_en = 1'b0; op_field = '0; ac_in = '0; e_in = 1'b0; pc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ac_out", 32'(ac_out), 32'h0);
        chk("R1 e_out", 32'(e_out), 32'h0);
        chk("R1 skip_req", 32'(skip_req), 32'h0);
        chk("R1 halted", 32'(halted), 32'h0);
        chk("R1 pc_next", 32'(pc_next), 32'h0);

        for (int i = 0; i < NV; i++) begin
            strobe(VECS[i].op, VECS[i].ac, VECS[i].e, 12'h100);
            chk($sformatf("R%0d vec%0d ac", VECS[i].req, i), 32'(ac_out), 32'(VECS[i].xac));
            chk($sformatf("R%0d vec%0d e", VECS[i].req, i), 32'(e_out), 32'(VECS[i].xe));
            chk($sformatf("R%0d vec%0d skip", VECS[i].req, i), 32'(skip_req), 32'(VECS[i].xs));
            chk($sformatf("R11 vec%0d pc", i), 32'(pc_next), 32'(12'h100 + 12'(VECS[i].xs)));
        end

        // R11 wrap of the program counter on skip
        strobe(12'h004, 16'h0000, 1'b0, 12'hFFF);
        chk("R11 pc wrap", 32'(pc_next), 32'h000);
        chk("R7 skip at wrap", 32'(skip_req), 32'h1);
        // R10 idle cycle: skip drops, values hold
        @(negedge clk);
        chk("R10 skip pulse ends", 32'(skip_req), 32'h0);
        chk("R10 ac hold", 32'(ac_out), 32'h0000);
        chk("R10 pc hold", 32'(pc_next), 32'h000);

        // R9 halt with invert in the same word
        strobe(12'h201, 16'h0F0F, 1'b0, 12'h020);
        chk("R9 halted set", 32'(halted), 32'h1);
        chk("R9 same-word invert", 32'(ac_out), 32'hF0F0);
        chk("R9 pc", 32'(pc_next), 32'h020);
        // R9 later strobes ignored
        strobe(12'hB00, 16'hAAAA, 1'b1, 12'h055);
        chk("R9 ac held", 32'(ac_out), 32'hF0F0);
        chk("R9 e held", 32'(e_out), 32'h0);
        strobe(12'h004, 16'h0000, 1'b1, 12'h077);
        chk("R9 no skip", 32'(skip_req), 32'h0);
        chk("R9 pc held", 32'(pc_next), 32'h020);
        chk("R9 still halted", 32'(halted), 32'h1);

        // R1 reset clears halt
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 halt cleared", 32'(halted), 32'h0);
        chk("R1 ac cleared", 32'(ac_out), 32'h0);
        strobe(12'h100, 16'h0001, 1'b0, 12'h001);
        chk("R3 runs after reset", 32'(e_out), 32'h1);

        finish_run();
    end
endmodule